// File: doc/BRIEF.md
# SDRAM Command Front End with Software-Driven Bring-Up

This block sits between a host and an SDRAM device and turns host activity into SDRAM commands. Software programs three registers over a small register bus: a configuration word that describes the device geometry and its timing, a mode selector, and a refresh interval. It then touches the memory window through a one-cycle host request strobe. While the mode selector holds a special code, each host write fires exactly one SDRAM command of that kind: no-operation, precharge of all banks, auto-refresh or mode-register load. While it holds the normal code, each access becomes a plain read or write command.

Power-up sequencing is left to software. The expected order is a no-operation access, a pause of at least 200 us, one precharge-all, eight auto-refreshes, one mode-register load, and then a return to normal mode followed by one access. A built-in interval timer raises periodic auto-refresh requests. A refresh that falls due waits until the command in progress has finished its recovery time. The block also decodes the geometry fields into the device size in bytes.

Top module: `sdram_cmd_front`

## Requirements
- R1: The configuration word (register offset 0) holds the column field at bits [1:0] (column bits = field + 8), the row field at bits [3:2] (row bits = field + 11), the bank field at bit 4 (bank bits = field + 1) and the bus-width bit at bit 5 (1 = 16-bit, 0 = 32-bit). dev_bytes, also readable at offset 3, equals 2^(row+col+bank+1) for a 16-bit bus and 2^(row+col+bank+2) for a 32-bit bus. After reset the word is 0, giving 0x0040_0000.
- R2: The mode register (offset 1, bits [2:0]) accepts the codes 0 normal, 1 no-op, 2 precharge-all, 3 auto-refresh and 4 mode load. A write of 5, 6 or 7 leaves the stored code unchanged. The reset value is 0.
- R3: A host write accepted while a special mode is selected drives exactly one command. It appears on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} in the cycle after acceptance: no-op 0111, precharge 0010, auto-refresh 0001, mode load 0000. In every other cycle the pins idle at 1111. An access is accepted at a clock edge where host_req is 1 and host_wait is 0.
- R4: A precharge-all command drives sd_a[10] high, every other sd_a bit low and sd_ba to 0.
- R5: A mode-load command drives sd_ba to 0, sd_a[2:0] to the BURST_CODE parameter (default 3'b010), sd_a[3] to 0 and sd_a[6:4] to {0, CAS field}, with the CAS field at configuration bits [7:6]. All higher bits are 0, and the host address is not used.
- R6: After a precharge, host_wait stays high for tRP cycles (configuration bits [19:16]). After an auto-refresh it stays high for tRC cycles (bits [15:12]). No command appears on the pins during this wait.
- R7: A host read accepted while a special mode is selected drives no command.
- R8: In normal mode an accepted write drives 0100 and an accepted read drives 0101. sd_a carries the low column-count bits of host_addr, and all higher sd_a bits are 0. sd_ba bit 0 carries host_addr[col+row]. sd_ba bit 1 carries host_addr[col+row+1] when the bank field is 1 and is 0 when the field is 0.
- R9: With a refresh interval P (offset 2) above zero, auto-refresh commands are issued every P cycles while no other command is pending. Writing the interval restarts the count. P = 0 stops all automatic refreshes.
- R10: A due refresh is issued as soon as no recovery wait is running, and it takes precedence over a host request in the same cycle. host_wait is high while a refresh is due, and command spacing still respects R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 config, 1 mode, 2 refresh interval, 3 size (read only) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| host_req | input | 1 | Host access strobe into the memory window |
| host_we | input | 1 | Host access direction, 1 = write |
| host_addr | input | ADDR_W (28) | Host word address |
| host_wait | output | 1 | Host must hold off its access |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_a | output | A_W (13) | SDRAM address pins |
| sd_ba | output | 2 | SDRAM bank select |
| dev_bytes | output | 32 | Decoded device size in bytes |

## Verification
The in-RTL assertions check several rules on every cycle: the stored mode code is always legal, and no command is issued while a recovery count is running. They also check that every precharge drives A10 with bank zero, that a mode load carries bank zero and the configured CAS latency, that read and write commands come only from normal mode, that a refresh which is due and unblocked goes out at once, and that a zero interval never leaves a refresh pending. The bench scenarios cover the rest. These are the size decode across several geometries, the exact command count per access during bring-up, and the length of the wait windows. They also cover the column and bank extraction from host addresses, the ignored reads and illegal codes, the measured refresh interval, and the spacing of commands when timer refreshes collide with a stream of back-to-back precharges.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

   typedef enum logic [2:0] {
      MODE_NORMAL    = 3'd0,
      MODE_NOP       = 3'd1,
      MODE_PRECHARGE = 3'd2,
      MODE_AUTOREF   = 3'd3,
      MODE_LOADMODE  = 3'd4
   } sdr_mode_e;

   // command encodings on {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_IDLE = 4'b1111;
   localparam logic [3:0] CMD_NOP  = 4'b0111;
   localparam logic [3:0] CMD_PRE  = 4'b0010;
   localparam logic [3:0] CMD_REF  = 4'b0001;
   localparam logic [3:0] CMD_LMR  = 4'b0000;
   localparam logic [3:0] CMD_RD   = 4'b0101;
   localparam logic [3:0] CMD_WR   = 4'b0100;

   localparam logic [1:0] RA_CFG   = 2'd0;
   localparam logic [1:0] RA_MODE  = 2'd1;
   localparam logic [1:0] RA_TIMER = 2'd2;
   localparam logic [1:0] RA_SIZE  = 2'd3;

   typedef struct packed {
      logic [3:0] t_xsr;
      logic [3:0] t_ras;
      logic [3:0] t_rcd;
      logic [3:0] t_rp;
      logic [3:0] t_rc;
      logic [3:0] t_wr;
      logic [1:0] cas;
      logic       bus16;
      logic       bank_f;
      logic [1:0] row_f;
      logic [1:0] col_f;
   } sdr_cfg_t;

   function automatic logic [5:0] size_log2(input sdr_cfg_t c);
      return 6'(c.col_f) + 6'd8 + 6'(c.row_f) + 6'd11 + 6'(c.bank_f) + 6'd1
             + (c.bus16 ? 6'd1 : 6'd2);
   endfunction

endpackage

// File: rtl/sdr_cfg_regs.sv
module sdr_cfg_regs
   import sdr_pkg::*;
#(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output sdr_mode_e        mode_o,
   output logic [1:0]       col_f_o,
   output logic [1:0]       row_f_o,
   output logic             bank_f_o,
   output logic [1:0]       cas_o,
   output logic [3:0]       trp_o,
   output logic [3:0]       trc_o,
   output logic [TMR_W-1:0] period_o,
   output logic [31:0]      dev_bytes_o
);

   if (TMR_W < 2 || TMR_W > 32) begin : g_bad_tmr_w
      $error("sdr_cfg_regs: TMR_W must lie in 2..32");
   end

   sdr_cfg_t         cfg_q;
   sdr_mode_e        mode_q;
   logic [TMR_W-1:0] period_q;
   logic [31:0]      bytes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         mode_q   <= MODE_NORMAL;
         period_q <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            RA_CFG:   cfg_q <= sdr_cfg_t'(reg_wdata);
            RA_MODE:  if (reg_wdata[2:0] <= 3'd4) mode_q <= sdr_mode_e'(reg_wdata[2:0]);
            RA_TIMER: period_q <= reg_wdata[TMR_W-1:0];
            default:  ;
         endcase
      end
   end

   assign bytes = 32'd1 << size_log2(cfg_q);

   always_comb begin
      case (reg_addr)
         RA_CFG:   reg_rdata = cfg_q;
         RA_MODE:  reg_rdata = {29'd0, mode_q};
         RA_TIMER: reg_rdata = 32'(period_q);
         default:  reg_rdata = bytes;
      endcase
   end

   assign mode_o      = mode_q;
   assign col_f_o     = cfg_q.col_f;
   assign row_f_o     = cfg_q.row_f;
   assign bank_f_o    = cfg_q.bank_f;
   assign cas_o       = cfg_q.cas;
   assign trp_o       = cfg_q.t_rp;
   assign trc_o       = cfg_q.t_rc;
   assign period_o    = period_q;
   assign dev_bytes_o = bytes;

   // R2: stored code never leaves the legal set
   assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (3'(mode_q) <= 3'd4));

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] period_i,
   input  logic             restart_i,
   input  logic             grant_i,
   output logic             pending_o
);

   logic [TMR_W-1:0] tick_q;
   logic             due_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         due_q  <= 1'b0;
      end else if (period_i == '0) begin
         tick_q <= '0;
         due_q  <= 1'b0;
      end else begin
         if (grant_i) due_q <= 1'b0;
         if (restart_i) begin
            tick_q <= '0;
         end else if (tick_q >= period_i - TMR_W'(1)) begin
            tick_q <= '0;
            due_q  <= 1'b1;
         end else begin
            tick_q <= tick_q + TMR_W'(1);
         end
      end
   end

   assign pending_o = due_q;

   // R9: a zero interval held for a cycle leaves nothing pending
   assert_refresh_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((period_i == '0) && ($past(period_i) == '0)) |-> !due_q);

endmodule

// File: rtl/sdr_cmd_issuer.sv
module sdr_cmd_issuer
   import sdr_pkg::*;
#(
   parameter int         ADDR_W     = 28,
   parameter int         A_W        = 13,
   parameter logic [2:0] BURST_CODE = 3'b010,
   parameter int         CNT_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sdr_mode_e         mode_i,
   input  logic [1:0]        col_f_i,
   input  logic [1:0]        row_f_i,
   input  logic              bank_f_i,
   input  logic [1:0]        cas_i,
   input  logic [CNT_W-1:0]  trp_i,
   input  logic [CNT_W-1:0]  trc_i,
   input  logic              ref_pend_i,
   input  logic              host_req_i,
   input  logic              host_we_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   output logic [3:0]        cmd_o,
   output logic [A_W-1:0]    a_o,
   output logic [1:0]        ba_o,
   output logic              wait_o,
   output logic              grant_o
);

   localparam int PRE_BIT = 10;

   logic [CNT_W-1:0] cnt_q, ld_val;
   logic [3:0]       cmd_q, cmd_d;
   logic [A_W-1:0]   a_q, a_d, a_norm, a_lmr, a_pre;
   logic [1:0]       ba_q, ba_d, ba_norm;
   logic [4:0]       col_n, row_n, bank_sh;
   logic             busy, accept, grant, load;

   assign busy   = (cnt_q != '0);
   assign grant  = ref_pend_i && !busy;
   assign accept = host_req_i && !busy && !ref_pend_i;

   assign col_n   = 5'(col_f_i) + 5'd8;
   assign row_n   = 5'(row_f_i) + 5'd11;
   assign bank_sh = col_n + row_n;

   assign a_norm     = host_addr_i[A_W-1:0] & ~({A_W{1'b1}} << col_n);
   assign ba_norm[0] = host_addr_i[bank_sh];
   assign ba_norm[1] = bank_f_i & host_addr_i[bank_sh + 5'd1];

   always_comb begin
      a_lmr      = '0;
      a_lmr[2:0] = BURST_CODE;
      a_lmr[6:4] = {1'b0, cas_i};
      a_pre          = '0;
      a_pre[PRE_BIT] = 1'b1;
   end

   always_comb begin
      cmd_d  = CMD_IDLE;
      a_d    = '0;
      ba_d   = '0;
      load   = 1'b0;
      ld_val = '0;
      if (grant) begin
         cmd_d  = CMD_REF;
         load   = 1'b1;
         ld_val = trc_i;
      end else if (accept) begin
         case (mode_i)
            MODE_NORMAL: begin
               cmd_d = host_we_i ? CMD_WR : CMD_RD;
               a_d   = a_norm;
               ba_d  = ba_norm;
            end
            MODE_NOP: if (host_we_i) cmd_d = CMD_NOP;
            MODE_PRECHARGE: if (host_we_i) begin
               cmd_d  = CMD_PRE;
               a_d    = a_pre;
               load   = 1'b1;
               ld_val = trp_i;
            end
            MODE_AUTOREF: if (host_we_i) begin
               cmd_d  = CMD_REF;
               load   = 1'b1;
               ld_val = trc_i;
            end
            MODE_LOADMODE: if (host_we_i) begin
               cmd_d = CMD_LMR;
               a_d   = a_lmr;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cmd_q <= CMD_IDLE;
         a_q   <= '0;
         ba_q  <= '0;
      end else begin
         cmd_q <= cmd_d;
         a_q   <= a_d;
         ba_q  <= ba_d;
         if (load)      cnt_q <= ld_val;
         else if (busy) cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign cmd_o   = cmd_q;
   assign a_o     = a_q;
   assign ba_o    = ba_q;
   assign wait_o  = busy | ref_pend_i;
   assign grant_o = grant;

   // R6: a command only follows a cycle with no recovery count running
   assert_no_cmd_in_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q != CMD_IDLE) |-> ($past(cnt_q) == '0));

   // R4: precharge-all carries A10 and bank zero
   assert_pre_all_a10_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_PRE) |-> (a_q[PRE_BIT] && (ba_q == 2'b00)));

   // R5: mode load uses controller-generated fields
   assert_lmr_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_LMR) |-> ((ba_q == 2'b00) && (a_q[6:4] == {1'b0, $past(cas_i)})
                              && (a_q[2:0] == BURST_CODE)));

   // R8: plain reads and writes only come from normal mode
   assert_rw_from_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_q == CMD_RD) || (cmd_q == CMD_WR)) |-> ($past(mode_i) == MODE_NORMAL));

   // R10: a due and unblocked refresh goes out on the next cycle
   assert_refresh_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q != CMD_REF) |-> !$past(ref_pend_i && (cnt_q == '0)));

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
   import sdr_pkg::*;
#(
   parameter int         ADDR_W     = 28,
   parameter int         A_W        = 13,
   parameter int         TMR_W      = 16,
   parameter logic [2:0] BURST_CODE = 3'b010,
   parameter bit         REFRESH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   output logic              host_wait,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [A_W-1:0]    sd_a,
   output logic [1:0]        sd_ba,
   output logic [31:0]       dev_bytes
);

   localparam int MAX_GEOM_BITS = 11 + 14 + 2;
   localparam int CNT_W         = 4;

   if (A_W < 11) begin : g_bad_a_w
      $error("sdram_cmd_front: A_W must hold A10 and 11 column bits");
   end
   if (ADDR_W < MAX_GEOM_BITS || ADDR_W < A_W) begin : g_bad_addr_w
      $error("sdram_cmd_front: ADDR_W too narrow for the largest geometry");
   end

   sdr_mode_e        mode;
   logic [1:0]       col_f, row_f, cas;
   logic             bank_f, ref_pend, ref_grant, tmr_restart;
   logic [CNT_W-1:0] trp, trc;
   logic [TMR_W-1:0] period;
   logic [3:0]       cmd;

   sdr_cfg_regs #(.TMR_W(TMR_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .mode_o      (mode),
      .col_f_o     (col_f),
      .row_f_o     (row_f),
      .bank_f_o    (bank_f),
      .cas_o       (cas),
      .trp_o       (trp),
      .trc_o       (trc),
      .period_o    (period),
      .dev_bytes_o (dev_bytes)
   );

   assign tmr_restart = reg_wr && (reg_addr == RA_TIMER);

   if (REFRESH_EN) begin : g_refresh
      sdr_refresh_timer #(.TMR_W(TMR_W)) u_timer (
         .clk       (clk),
         .rst_n     (rst_n),
         .period_i  (period),
         .restart_i (tmr_restart),
         .grant_i   (ref_grant),
         .pending_o (ref_pend)
      );
   end else begin : g_no_refresh
      assign ref_pend = 1'b0;
   end

   sdr_cmd_issuer #(
      .ADDR_W     (ADDR_W),
      .A_W        (A_W),
      .BURST_CODE (BURST_CODE),
      .CNT_W      (CNT_W)
   ) u_issuer (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode),
      .col_f_i     (col_f),
      .row_f_i     (row_f),
      .bank_f_i    (bank_f),
      .cas_i       (cas),
      .trp_i       (trp),
      .trc_i       (trc),
      .ref_pend_i  (ref_pend),
      .host_req_i  (host_req),
      .host_we_i   (host_we),
      .host_addr_i (host_addr),
      .cmd_o       (cmd),
      .a_o         (sd_a),
      .ba_o        (sd_ba),
      .wait_o      (host_wait),
      .grant_o     (ref_grant)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: tb/sdram_cmd_front_tb.sv
module sdram_cmd_front_tb;

   localparam int ADDR_W = 28;
   localparam int A_W    = 13;
   localparam int TRP    = 3;
   localparam int TRC    = 5;
   // col=1, row=2, bank=1, 32-bit, cas=2, twr=2, trc=5, trp=3, trcd=2, tras=4, txsr=6
   localparam logic [31:0] BRING_CFG = 32'h6423_5299;

   // {config word, expected size in bytes}
   localparam logic [63:0] SIZE_VEC [0:4] = '{
      {32'h0000_0000, 32'h0040_0000},
      {32'h0000_0020, 32'h0020_0000},
      {32'h0000_001F, 32'h2000_0000},
      {32'h0000_0029, 32'h0100_0000},
      {32'h0000_0036, 32'h0200_0000}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [1:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              host_req = 1'b0;
   logic              host_we = 1'b0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic              host_wait;
   logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [A_W-1:0]    sd_a;
   logic [1:0]        sd_ba;
   logic [31:0]       dev_bytes;

   int nchk = 0, nerr = 0;
   int cyc = 0, n_cmd = 0, n_nop = 0, n_pre = 0, n_ref = 0, n_lmr = 0, n_rw = 0;
   int viol = 0, prev_cyc = 0, need = 0, ref_last = 0, ref_prev = 0;
   bit have_prev = 0;
   logic [3:0]     last_cmd = 4'hF;
   logic [A_W-1:0] last_a = '0;
   logic [1:0]     last_ba = '0;

   always #5 clk = ~clk;

   sdram_cmd_front u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_req(host_req),
      .host_we(host_we), .host_addr(host_addr), .host_wait(host_wait),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_a(sd_a), .sd_ba(sd_ba), .dev_bytes(dev_bytes)
   );

   // pin monitor: counts commands and checks spacing against tRP / tRC
   always @(negedge clk) begin
      logic [3:0] c;
      cyc++;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (rst_n && c != 4'b1111) begin
         n_cmd++;
         if (have_prev && (cyc - prev_cyc) < need) viol++;
         have_prev = 1;
         prev_cyc  = cyc;
         need      = 1;
         case (c)
            4'b0111: n_nop++;
            4'b0010: begin n_pre++; need = TRP + 1; end
            4'b0001: begin n_ref++; need = TRC + 1; ref_prev = ref_last; ref_last = cyc; end
            4'b0000: n_lmr++;
            default: n_rw++;
         endcase
         last_cmd = c;
         last_a   = sd_a;
         last_ba  = sd_ba;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] addr, input logic [31:0] data);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] addr, output logic [31:0] data);
      @(negedge clk);
      reg_addr = addr;
      #1 data = reg_rdata;
   endtask

   task automatic host_access(input logic we, input logic [ADDR_W-1:0] addr);
      @(negedge clk);
      while (host_wait) @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = addr;
      @(negedge clk);
      host_req = 1'b0;
      #1;
   endtask

   task automatic count_wait(output int n);
      n = 0;
      while (host_wait) begin
         n++;
         @(negedge clk);
         #1;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int n, base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;

      // reset state
      check("R3 idle pins after reset", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'hF);
      check("R6 no wait after reset", 32'(host_wait), 32'd0);
      check("R1 reset size", dev_bytes, 32'h0040_0000);
      reg_read(2'd1, rd);
      check("R2 reset mode", rd, 32'd0);

      // R1 geometry table
      for (int i = 0; i < 5; i++) begin
         reg_write(2'd0, SIZE_VEC[i][63:32]);
         reg_read(2'd3, rd);
         check("R1 size register", rd, SIZE_VEC[i][31:0]);
         check("R1 size port", dev_bytes, SIZE_VEC[i][31:0]);
         reg_read(2'd0, rd);
         check("R1 config readback", rd, SIZE_VEC[i][63:32]);
      end

      // bring-up
      reg_write(2'd0, BRING_CFG);
      check("R1 bring-up size", dev_bytes, 32'h0400_0000);
      reg_write(2'd1, 32'd1);
      host_access(1'b1, 28'h000_0000);
      check("R3 nop command", 32'(last_cmd), 32'h7);
      repeat (3) @(negedge clk);
      check("R3 exactly one nop", 32'(n_cmd), 32'd1);

      reg_write(2'd1, 32'd2);
      host_access(1'b1, 28'h0C0_0123);
      check("R3 precharge command", 32'(last_cmd), 32'h2);
      check("R4 precharge A10 only", 32'(last_a), 32'h400);
      check("R4 precharge bank zero", 32'(last_ba), 32'd0);
      count_wait(n);
      check("R6 wait after precharge", 32'(n), 32'(TRP));

      reg_write(2'd1, 32'd3);
      for (int i = 0; i < 8; i++) host_access(1'b1, 28'(i));
      count_wait(n);
      check("R6 wait after auto-refresh", 32'(n), 32'(TRC));
      check("R3 eight auto-refresh", 32'(n_ref), 32'd8);
      check("R6 spacing during bring-up", 32'(viol), 32'd0);

      // R7: read in special mode is ignored
      base = n_cmd;
      host_access(1'b0, 28'h000_0010);
      repeat (2) @(negedge clk);
      #1;
      check("R7 read fires no command", 32'(n_cmd), 32'(base));
      check("R7 no wait after read", 32'(host_wait), 32'd0);

      reg_write(2'd1, 32'd4);
      host_access(1'b1, 28'h0C0_0123);
      check("R5 mode load command", 32'(last_cmd), 32'h0);
      check("R5 mode load address", 32'(last_a), 32'h22);
      check("R5 mode load bank", 32'(last_ba), 32'd0);
      check("R3 exactly one mode load", 32'(n_lmr), 32'd1);

      // R2 illegal codes
      reg_write(2'd1, 32'd6);
      reg_read(2'd1, rd);
      check("R2 code 6 ignored", rd, 32'd4);
      reg_write(2'd1, 32'd0);
      reg_read(2'd1, rd);
      check("R2 normal code stored", rd, 32'd0);

      // R8 normal accesses
      host_access(1'b1, 28'h0C0_0123);
      check("R8 write command", 32'(last_cmd), 32'h4);
      check("R8 write column", 32'(last_a), 32'h123);
      check("R8 write bank", 32'(last_ba), 32'd3);
      host_access(1'b0, 28'h040_0045);
      check("R8 read command", 32'(last_cmd), 32'h5);
      check("R8 read column", 32'(last_a), 32'h045);
      check("R8 read bank", 32'(last_ba), 32'd1);

      // R9 periodic refresh
      base = n_ref;
      reg_write(2'd2, 32'd20);
      repeat (70) @(negedge clk);
      #1;
      check("R9 at least three refreshes", 32'((n_ref - base) >= 3), 32'd1);
      check("R9 refresh interval", 32'(ref_last - ref_prev), 32'd20);
      reg_write(2'd2, 32'd0);
      repeat (2) @(negedge clk);
      base = n_ref;
      repeat (60) @(negedge clk);
      #1;
      check("R9 zero interval stops refresh", 32'(n_ref), 32'(base));

      // R10 timer refresh interleaved with back-to-back precharges
      reg_write(2'd1, 32'd2);
      base = n_ref;
      viol = 0;
      reg_write(2'd2, 32'd15);
      for (int i = 0; i < 12; i++) host_access(1'b1, 28'(i));
      count_wait(n);
      check("R10 refresh issued among precharges", 32'((n_ref - base) >= 2), 32'd1);
      check("R10 spacing kept", 32'(viol), 32'd0);
      reg_write(2'd2, 32'd0);

      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule